// File: doc/BRIEF.md
# Programming Pulse Width Timer

This block times one programming pulse for a nonvolatile memory write. Its clock runs at the oscillator frequency. A start strobe launches the pulse. The length comes from a 16-bit configuration word whose low 15 bits give a width value. Time is counted in coarse steps of 144 oscillator cycles, produced by a divider that restarts at each accepted start. A pulse lasts (value + 1) steps. The top bit of the word must be set, or the start is refused and an error flag is raised.

Two configuration registers share one layout and differ only in their reset value. The slot-0 default is 0x8005, which is long enough at an 8 MHz oscillator. The slot-1 default is 0x8013, deliberately longer than needed. Each register can be written through a write port or loaded through a port fed by an external source. The start strobe carries a selector that picks which register times the pulse. The block only counts clocks. Choosing a value that yields at least 100 µs at the actual oscillator frequency is left to whoever fills the register.

Top module: `ppw_timer`

## Requirements
- R1: After synchronous reset, `pulse_active`, `pulse_done` and `cfg_error` are all 0.
- R2: A start accepted with a selected word whose bit 15 is 1 and bits 14:0 equal V drives `pulse_active` high from the cycle after the start for exactly (V + 1) × 144 clock cycles. The first 144-cycle step completes 144 cycles after the start edge.
- R3: `pulse_done` is high for exactly one cycle, and that cycle is the first cycle in which `pulse_active` is low after a pulse. At no other time is it high.
- R4: A start whose selected word has bit 15 equal to 0 produces no pulse and sets `cfg_error` from the next cycle on. `cfg_error` stays set until a start is accepted, which clears it.
- R5: A start strobe that arrives while `pulse_active` is high is ignored. The running pulse keeps its length, and no second pulse follows.
- R6: Register slot 0 resets to 0x8005 and slot 1 resets to 0x8013. `start_sel` (0 or 1) chooses the slot that times the pulse.
- R7: `wr_en` stores `wr_data` into slot `wr_sel`, and `ld_en` stores `ld_data` into slot `ld_sel`, both on the next clock edge. When both target the same slot in the same cycle, the loaded value wins.
- R8: The width is captured at the start. Changing the selected register while a pulse runs does not alter that pulse, but it does apply to the next one.
- R9: A width value of 0 with bit 15 set gives the shortest pulse, 144 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator-rate clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for a configuration slot |
| wr_sel | input | 1 | Slot targeted by the write |
| wr_data | input | 16 | Word to write |
| ld_en | input | 1 | Load strobe from the external source |
| ld_sel | input | 1 | Slot targeted by the load |
| ld_data | input | 16 | Word to load |
| start | input | 1 | Pulse launch strobe |
| start_sel | input | 1 | Slot that times the pulse |
| pulse_active | output | 1 | High while the programming pulse is on |
| pulse_done | output | 1 | One-cycle strobe as the pulse ends |
| cfg_error | output | 1 | Set by a start refused for a clear bit 15 |

## Verification
The hardest case to reach from the ports is a change that lands in the middle of a running pulse. This covers a second start strobe and a rewrite of the very register that timed the pulse. Either one could silently stretch, cut or restart the pulse. The stimulus reaches this case by launching a pulse and waiting a fixed number of cycles. It then fires the strobe or rewrites the register while `pulse_active` is still high. The scoreboard expects the pulse length fixed at launch, and it flags any pulse that has no queued expectation.

// File: rtl/ppt_pkg.sv
package ppt_pkg;

    localparam int CFG_W = 16;
    localparam int VAL_W = CFG_W - 1;

    typedef logic [CFG_W-1:0] cfg_word_t;
    typedef logic [VAL_W-1:0] width_t;

    // Bit 15 is the mandatory-set flag, bits 14:0 the width in prescaled steps.
    typedef struct packed {
        logic   enable_ok;
        width_t width;
    } cfg_t;

    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_PULSE = 1'b1
    } pulse_state_t;

    function automatic cfg_t decode_cfg(input cfg_word_t w);
        return cfg_t'(w);
    endfunction

    function automatic logic cfg_usable(input cfg_t c);
        return c.enable_ok;
    endfunction

endpackage

// File: rtl/ppt_cfg_reg.sv
module ppt_cfg_reg
    import ppt_pkg::*;
#(
    parameter cfg_word_t RESET_VAL = 16'h8005
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      wr_en,
    input  cfg_word_t wr_data,
    input  logic      ld_en,
    input  cfg_word_t ld_data,
    output cfg_word_t q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= RESET_VAL;
        end else if (ld_en) begin
            q <= ld_data;
        end else if (wr_en) begin
            q <= wr_data;
        end
    end

    // R7: load path has priority and lands on the next edge
    p_load_lands_r7: assert property (@(posedge clk) disable iff (rst)
        ld_en |=> q == $past(ld_data));

    // R7: write alone lands on the next edge
    p_write_lands_r7: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !ld_en) |=> q == $past(wr_data));

    // R8: without a strobe the register holds
    p_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (!wr_en && !ld_en) |=> $stable(q));

endmodule

// File: rtl/ppt_prescaler.sv
module ppt_prescaler #(
    parameter int DIV = 144
) (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    input  logic run,
    output logic tick
);

    localparam int CNT_W = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DIV - 1);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            cnt <= '0;
        end else if (run) begin
            if (cnt == LAST) begin
                cnt <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    assign tick = run && (cnt == LAST);

    // R2: divider never leaves its range
    p_cnt_range_r2: assert property (@(posedge clk) disable iff (rst)
        cnt <= LAST);

    // R2: a restart always begins a fresh step
    p_restart_zero_r2: assert property (@(posedge clk) disable iff (rst)
        restart |=> cnt == '0);

endmodule

// File: rtl/ppt_pulse_ctrl.sv
module ppt_pulse_ctrl
    import ppt_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  cfg_t cfg,
    input  logic tick,
    output logic restart,
    output logic active,
    output logic done,
    output logic cfg_err
);

    pulse_state_t state;
    width_t       remaining;
    logic         accept;
    logic         refuse;

    assign accept  = (state == ST_IDLE) && start && cfg_usable(cfg);
    assign refuse  = (state == ST_IDLE) && start && !cfg_usable(cfg);
    assign restart = accept;
    assign active  = (state == ST_PULSE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            remaining <= '0;
            done      <= 1'b0;
            cfg_err   <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (accept) begin
                        state     <= ST_PULSE;
                        remaining <= cfg.width;
                        cfg_err   <= 1'b0;
                    end else if (refuse) begin
                        cfg_err <= 1'b1;
                    end
                end
                ST_PULSE: begin
                    if (tick) begin
                        if (remaining == '0) begin
                            state <= ST_IDLE;
                            done  <= 1'b1;
                        end else begin
                            remaining <= remaining - 1'b1;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R3: done coincides with the first idle cycle after a pulse
    p_done_on_fall_r3: assert property (@(posedge clk) disable iff (rst)
        done |-> (!active && $past(active)));

    // R3: done is a single-cycle strobe
    p_done_single_r3: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R4: a refused start leaves the timer idle and flags the error
    p_refuse_r4: assert property (@(posedge clk) disable iff (rst)
        (start && !active && !cfg.enable_ok) |=> (!active && cfg_err));

    // R5: a start during a pulse does not reload the count
    p_ignore_start_r5: assert property (@(posedge clk) disable iff (rst)
        (start && active && !tick) |=> (active && $stable(remaining)));

    // R2: the pulse ends only on a step boundary
    p_end_on_tick_r2: assert property (@(posedge clk) disable iff (rst)
        (active && !tick) |=> active);

endmodule

// File: rtl/ppw_timer.sv
module ppw_timer
    import ppt_pkg::*;
#(
    parameter int             PRESCALE = 144,
    parameter int             NUM_CFG  = 2,
    parameter logic [NUM_CFG*CFG_W-1:0] DEFAULTS = {16'h8013, 16'h8005},
    localparam int            SEL_W    = (NUM_CFG > 1) ? $clog2(NUM_CFG) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [SEL_W-1:0] wr_sel,
    input  logic [15:0]      wr_data,
    input  logic             ld_en,
    input  logic [SEL_W-1:0] ld_sel,
    input  logic [15:0]      ld_data,
    input  logic             start,
    input  logic [SEL_W-1:0] start_sel,
    output logic             pulse_active,
    output logic             pulse_done,
    output logic             cfg_error
);

    cfg_word_t cfg_words [NUM_CFG];
    cfg_t      sel_cfg;
    logic      tick;
    logic      restart;

    for (genvar i = 0; i < NUM_CFG; i++) begin : g_cfg
        ppt_cfg_reg #(
            .RESET_VAL(DEFAULTS[i*CFG_W +: CFG_W])
        ) u_reg (
            .clk    (clk),
            .rst    (rst),
            .wr_en  (wr_en && (wr_sel == SEL_W'(i))),
            .wr_data(wr_data),
            .ld_en  (ld_en && (ld_sel == SEL_W'(i))),
            .ld_data(ld_data),
            .q      (cfg_words[i])
        );
    end

    assign sel_cfg = decode_cfg(cfg_words[start_sel]);

    ppt_prescaler #(
        .DIV(PRESCALE)
    ) u_presc (
        .clk    (clk),
        .rst    (rst),
        .restart(restart),
        .run    (pulse_active),
        .tick   (tick)
    );

    ppt_pulse_ctrl u_ctrl (
        .clk    (clk),
        .rst    (rst),
        .start  (start),
        .cfg    (sel_cfg),
        .tick   (tick),
        .restart(restart),
        .active (pulse_active),
        .done   (pulse_done),
        .cfg_err(cfg_error)
    );

    // R1: outputs quiet right after reset
    p_reset_quiet_r1: assert property (@(posedge clk)
        $past(rst) |-> (!pulse_active && !pulse_done && !cfg_error));

endmodule

// File: tb/ppw_timer_tb.sv
module ppw_timer_tb;

    localparam int CLK_PERIOD = 10;
    localparam int STEP       = 144;
    localparam int WATCHDOG   = 150000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [0:0]  wr_sel = '0;
    logic [15:0] wr_data = '0;
    logic        ld_en = 1'b0;
    logic [0:0]  ld_sel = '0;
    logic [15:0] ld_data = '0;
    logic        start = 1'b0;
    logic [0:0]  start_sel = '0;
    logic        pulse_active;
    logic        pulse_done;
    logic        cfg_error;

    int vectors = 0;
    int miscompares = 0;
    int exp_q[$];
    string tag_q[$];
    int cycles = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ppw_timer u_dut (
        .clk(clk), .rst(rst),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .ld_en(ld_en), .ld_sel(ld_sel), .ld_data(ld_data),
        .start(start), .start_sel(start_sel),
        .pulse_active(pulse_active), .pulse_done(pulse_done),
        .cfg_error(cfg_error)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic summary_and_exit();
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    endtask

    // Watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG) begin
            check(1'b0, "watchdog", cycles, WATCHDOG);
            summary_and_exit();
        end
    end

    // Monitor: measures each pulse and compares with the scoreboard queue
    int  run_len = 0;
    bit  prev_active = 1'b0;
    always @(negedge clk) begin
        if (!rst) begin
            if (pulse_active) run_len++;
            if (prev_active && !pulse_active) begin
                check(pulse_done == 1'b1, "R3 done at fall", int'(pulse_done), 1);
                if (exp_q.size() == 0) begin
                    check(1'b0, "R5 unexpected pulse", run_len, 0);
                end else begin
                    automatic int e = exp_q.pop_front();
                    automatic string t = tag_q.pop_front();
                    check(run_len == e, t, run_len, e);
                end
                run_len = 0;
            end else if (pulse_done) begin
                check(1'b0, "R3 stray done", 1, 0);
            end
            prev_active = pulse_active;
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic write_cfg(input bit sel, input logic [15:0] d);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        cyc(1);
        wr_en = 1'b0;
    endtask

    task automatic load_cfg(input bit sel, input logic [15:0] d);
        ld_en = 1'b1; ld_sel = sel; ld_data = d;
        cyc(1);
        ld_en = 1'b0;
    endtask

    // Driver: launches a pulse and queues its expected length
    task automatic launch(input bit sel, input int width_val, input string tag);
        exp_q.push_back((width_val + 1) * STEP);
        tag_q.push_back(tag);
        start = 1'b1; start_sel = sel;
        cyc(1);
        start = 1'b0;
    endtask

    task automatic wait_drained();
        while (exp_q.size() != 0) cyc(1);
        cyc(1);
    endtask

    initial begin
        cyc(3);
        rst = 1'b0;
        cyc(1);
        // R1
        check(!pulse_active && !pulse_done && !cfg_error, "R1 reset state",
              {pulse_active, pulse_done, cfg_error}, 0);

        // R6 defaults
        launch(1'b0, 5, "R6 slot0 default length");
        check(pulse_active == 1'b1, "R2 active after start", int'(pulse_active), 1);
        wait_drained();
        check(pulse_done == 1'b0, "R3 done one cycle", int'(pulse_done), 0);
        launch(1'b1, 19, "R6 slot1 default length");
        wait_drained();

        // R9 minimum width via write port (R7)
        write_cfg(1'b0, 16'h8000);
        launch(1'b0, 0, "R9 minimum width");
        cyc(STEP - 1);
        check(pulse_active == 1'b1, "R2 first step still on", int'(pulse_active), 1);
        wait_drained();

        // R4 clear top bit refused
        write_cfg(1'b1, 16'h000B);
        start = 1'b1; start_sel = 1'b1;
        cyc(1);
        start = 1'b0;
        check(cfg_error == 1'b1, "R4 error set", int'(cfg_error), 1);
        check(pulse_active == 1'b0, "R4 no pulse", int'(pulse_active), 0);
        cyc(20);
        check(pulse_active == 1'b0 && cfg_error == 1'b1, "R4 still idle, flag held",
              {pulse_active, cfg_error}, 1);

        // R4 clearing by accepted start
        write_cfg(1'b1, 16'h800B);
        launch(1'b1, 11, "R2 width 11");
        check(cfg_error == 1'b0, "R4 error cleared", int'(cfg_error), 0);
        wait_drained();

        // R5 start during a pulse
        write_cfg(1'b0, 16'h8003);
        launch(1'b0, 3, "R5 length unchanged by second start");
        cyc(300);
        start = 1'b1; start_sel = 1'b0;
        cyc(1);
        start = 1'b0;
        wait_drained();
        cyc(200);
        check(pulse_active == 1'b0, "R5 no second pulse", int'(pulse_active), 0);

        // R7 load wins over write on same slot
        wr_en = 1'b1; wr_sel = 1'b0; wr_data = 16'h8001;
        ld_en = 1'b1; ld_sel = 1'b0; ld_data = 16'h8002;
        cyc(1);
        wr_en = 1'b0; ld_en = 1'b0;
        launch(1'b0, 2, "R7 load priority");
        wait_drained();
        load_cfg(1'b1, 16'h8004);
        launch(1'b1, 4, "R7 load port");
        wait_drained();

        // R8 change during a pulse
        launch(1'b0, 2, "R8 running pulse unaffected");
        cyc(100);
        write_cfg(1'b0, 16'h8000);
        wait_drained();
        launch(1'b0, 0, "R8 new value on next pulse");
        wait_drained();

        cyc(5);
        summary_and_exit();
    end

endmodule